// File: doc/BRIEF.md
# Input Energy Accumulator

This block sums input power over an unbounded span, so that a host can work out average power over any interval it likes. Each valid sample brings a voltage code and a current code. The block multiplies them and keeps the upper bits of the product as the sample's power value. That value is added into a wrapping power accumulator. A rollover counter records how often the accumulator has wrapped, and a sample counter records how many samples have been taken. None of this depends on any averaging window.

A host reads the state by pulsing a snapshot request. All three counters are then frozen together into a holding register. That register is offered one byte at a time on a byte-serial port, which a serial management bus slave can forward as a block-read reply. The reply starts with a byte count, followed by the six payload bytes. The host takes two snapshots and divides the change in energy by the change in sample count to get average power.

Top module: `energy_accum`

## Requirements
- R1: After reset the accumulator, rollover counter and sample counter are zero and `frm_valid` is low.
- R2: For each cycle with `smp_valid` high, the power value is bits [23:12] of the unsigned product `smp_volt * smp_curr`, and it is added into the 16-bit accumulator.
- R3: When an addition carries out of the accumulator, the accumulator keeps the low 16 bits and the 8-bit rollover counter increments, wrapping from 255 to 0.
- R4: The 24-bit sample counter increments by one, modulo 2^24, for each cycle with `smp_valid` high.
- R5: In a cycle with `smp_valid` low, the codes on `smp_volt`/`smp_curr` leave every counter unchanged.
- R6: A `snap_req` captures the counter values including any sample valid in the same cycle. Samples that arrive after that cycle do not alter the frame being presented, and the counters are never cleared by a snapshot.
- R7: In the cycle after `snap_req`, `frm_valid` is high and the frame is offered in this order: byte count 6, accumulator bits [7:0], accumulator bits [15:8], rollover count, sample count bits [7:0], [15:8], [23:16]. `frm_last` is high with the seventh byte only.
- R8: A byte stays on `frm_byte` until `frm_ack` is high in a cycle. After `frm_ack` is given on the last byte, `frm_valid` is low in the next cycle.
- R9: A `snap_req` that arrives during a readout takes a fresh snapshot and restarts the frame at the byte-count byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_volt | input | 12 | Voltage code |
| smp_curr | input | 12 | Current code |
| snap_req | input | 1 | Snapshot request pulse |
| frm_ack | input | 1 | Consume the current frame byte |
| frm_valid | output | 1 | A frame byte is offered |
| frm_byte | output | 8 | Current frame byte |
| frm_last | output | 1 | Current byte is the last of the frame |

## Verification
A sample or snapshot request applied before a rising edge takes effect at that edge. The first frame byte is therefore due one cycle after `snap_req`, and each following byte is due one cycle after the `frm_ack` that consumes the byte before it. Inputs are driven and outputs are read at the falling edge, half a cycle after each effective edge. A sample sent in the same cycle as the request is entered into the bench's model before the expected frame is frozen. A sample sent after the request is entered only after the frame has been read.

// File: rtl/eacc_pkg.sv
package eacc_pkg;
   typedef logic [7:0] octet_t;
   // frame header: one byte-count byte precedes the payload
   localparam int HDR_BYTES = 1;
   function automatic int bytes_of(input int bits);
      return (bits + 7) / 8;
   endfunction
endpackage

// File: rtl/eacc_power.sv
module eacc_power #(
   parameter int SMP_W = 12,
   parameter int PWR_W = 12
) (
   input  logic [SMP_W-1:0] volt,
   input  logic [SMP_W-1:0] curr,
   output logic [PWR_W-1:0] pwr
);
   localparam int PROD_W = 2 * SMP_W;

   if (PWR_W > PROD_W) begin : g_bad_pwr
      $error("eacc_power: PWR_W exceeds product width");
   end

   logic [PROD_W-1:0] prod;

   always_comb begin
      prod = PROD_W'(volt) * PROD_W'(curr);
      pwr  = prod[PROD_W-1 -: PWR_W];
   end
endmodule

// File: rtl/eacc_accum.sv
module eacc_accum #(
   parameter int PWR_W  = 12,
   parameter int ACC_W  = 16,
   parameter int ROLL_W = 8,
   parameter int CNT_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [PWR_W-1:0]  pwr,
   output logic [ACC_W-1:0]  acc_nxt,
   output logic [ROLL_W-1:0] roll_nxt,
   output logic [CNT_W-1:0]  cnt_nxt
);
   if (PWR_W > ACC_W) begin : g_bad_acc
      $error("eacc_accum: PWR_W must not exceed ACC_W");
   end

   logic [ACC_W-1:0]  acc_q;
   logic [ROLL_W-1:0] roll_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ACC_W:0]    sum;

   always_comb begin
      sum      = {1'b0, acc_q} + (ACC_W+1)'(pwr);
      acc_nxt  = acc_q;
      roll_nxt = roll_q;
      cnt_nxt  = cnt_q;
      if (smp_valid) begin
         acc_nxt = sum[ACC_W-1:0];
         cnt_nxt = cnt_q + CNT_W'(1);
         if (sum[ACC_W]) roll_nxt = roll_q + ROLL_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q  <= '0;
         roll_q <= '0;
         cnt_q  <= '0;
      end else begin
         acc_q  <= acc_nxt;
         roll_q <= roll_nxt;
         cnt_q  <= cnt_nxt;
      end
   end

   // R5
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(acc_q) && $stable(roll_q) && $stable(cnt_q));
   // R4
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1)));
   // R3
   roll_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smp_valid |=> (roll_q != $past(roll_q)) == (acc_q < $past(acc_q)));
endmodule

// File: rtl/eacc_frame.sv
module eacc_frame
   import eacc_pkg::*;
#(
   parameter int PAY_W = 48
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snap_req,
   input  logic [PAY_W-1:0] pay,
   input  logic             frm_ack,
   output logic             frm_valid,
   output octet_t           frm_byte,
   output logic             frm_last
);
   localparam int PAY_BYTES   = bytes_of(PAY_W);
   localparam int FRAME_BYTES = PAY_BYTES + HDR_BYTES;
   localparam int IDX_W       = $clog2(FRAME_BYTES);
   localparam int SLOTS       = 2 ** IDX_W;

   if (PAY_W % 8 != 0) begin : g_bad_pay
      $error("eacc_frame: PAY_W must be a whole number of bytes");
   end

   logic [PAY_W-1:0] snap_q;
   logic [IDX_W-1:0] idx_q;
   logic             busy_q;
   octet_t           slot [SLOTS];

   assign slot[0] = octet_t'(PAY_BYTES);
   for (genvar k = 0; k < PAY_BYTES; k++) begin : g_pay_slot
      assign slot[k+1] = snap_q[k*8 +: 8];
   end
   for (genvar k = FRAME_BYTES; k < SLOTS; k++) begin : g_pad_slot
      assign slot[k] = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_q <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
      end else if (snap_req) begin
         snap_q <= pay;
         idx_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && frm_ack) begin
         if (idx_q == IDX_W'(FRAME_BYTES-1)) busy_q <= 1'b0;
         else                                idx_q  <= idx_q + IDX_W'(1);
      end
   end

   assign frm_valid = busy_q;
   assign frm_byte  = slot[idx_q];
   assign frm_last  = busy_q && (idx_q == IDX_W'(FRAME_BYTES-1));

   // R7
   hdr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> frm_valid && frm_byte == octet_t'(PAY_BYTES));
   // R8
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_valid && !frm_ack && !snap_req |=> frm_valid && $stable(frm_byte));
   // R8
   frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frm_last && frm_ack && !snap_req |=> !frm_valid);
endmodule

// File: rtl/energy_accum.sv
module energy_accum #(
   parameter int SMP_W  = 12,
   parameter int ACC_W  = 16,
   parameter int ROLL_W = 8,
   parameter int CNT_W  = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_volt,
   input  logic [SMP_W-1:0] smp_curr,
   input  logic             snap_req,
   input  logic             frm_ack,
   output logic             frm_valid,
   output logic [7:0]       frm_byte,
   output logic             frm_last
);
   localparam int PWR_W = SMP_W;
   localparam int PAY_W = ACC_W + ROLL_W + CNT_W;

   logic [PWR_W-1:0]  pwr;
   logic [ACC_W-1:0]  acc_nxt;
   logic [ROLL_W-1:0] roll_nxt;
   logic [CNT_W-1:0]  cnt_nxt;

   eacc_power #(.SMP_W(SMP_W), .PWR_W(PWR_W)) i_power (
      .volt(smp_volt), .curr(smp_curr), .pwr(pwr));

   eacc_accum #(.PWR_W(PWR_W), .ACC_W(ACC_W), .ROLL_W(ROLL_W), .CNT_W(CNT_W)) i_accum (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .pwr(pwr),
      .acc_nxt(acc_nxt), .roll_nxt(roll_nxt), .cnt_nxt(cnt_nxt));

   // next-state values make a same-cycle sample part of the snapshot (R6)
   eacc_frame #(.PAY_W(PAY_W)) i_frame (
      .clk(clk), .rst_n(rst_n), .snap_req(snap_req),
      .pay({cnt_nxt, roll_nxt, acc_nxt}), .frm_ack(frm_ack),
      .frm_valid(frm_valid), .frm_byte(frm_byte), .frm_last(frm_last));
endmodule

// File: tb/test_energy_accum.sv
module test_energy_accum;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_valid = 1'b0;
   logic [11:0] smp_volt = '0, smp_curr = '0;
   logic snap_req = 1'b0, frm_ack = 1'b0;
   logic frm_valid, frm_last;
   logic [7:0] frm_byte;

   int checks = 0, errors = 0;
   logic [15:0] m_acc = '0;
   logic [7:0]  m_roll = '0;
   logic [23:0] m_cnt = '0;
   logic [55:0] exp_frame;
   logic [7:0]  fr [7];

   // {volt, curr, expected power}
   localparam logic [35:0] VEC [8] = '{
      {12'hFFF, 12'hFFF, 12'd4094},
      {12'd2048, 12'd2048, 12'd1024},
      {12'd1, 12'hFFF, 12'd0},
      {12'd64, 12'd64, 12'd1},
      {12'd100, 12'd41, 12'd1},
      {12'd2048, 12'd16, 12'd8},
      {12'd3000, 12'd2000, 12'd1464},
      {12'hFFF, 12'd1, 12'd0}};

   energy_accum i_energy_accum (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_volt(smp_volt),
      .smp_curr(smp_curr), .snap_req(snap_req), .frm_ack(frm_ack),
      .frm_valid(frm_valid), .frm_byte(frm_byte), .frm_last(frm_last));

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_add(input logic [11:0] p);
      logic [16:0] t;
      t = {1'b0, m_acc} + 17'(p);
      if (t[16]) m_roll = m_roll + 8'd1;
      m_acc = t[15:0];
      m_cnt = m_cnt + 24'd1;
   endtask

   function automatic logic [55:0] model_frame();
      return {m_cnt, m_roll, m_acc, 8'd6};
   endfunction

   task automatic send(input logic [11:0] v, input logic [11:0] c, input logic [11:0] p);
      smp_valid = 1'b1; smp_volt = v; smp_curr = c;
      @(negedge clk);
      smp_valid = 1'b0;
      model_add(p);
   endtask

   task automatic snap_now();
      snap_req = 1'b1;
      exp_frame = model_frame();
      @(negedge clk);
      snap_req = 1'b0;
   endtask

   task automatic drain(input string req);
      logic [55:0] act;
      for (int i = 0; i < 7; i++) begin
         fr[i] = frm_byte;
         chk(frm_valid === 1'b1, "R7 valid", 64'(frm_valid), 64'd1);
         chk(frm_last === (i == 6), "R7 last", 64'(frm_last), 64'(i == 6));
         frm_ack = 1'b1;
         @(negedge clk);
         frm_ack = 1'b0;
      end
      chk(frm_valid === 1'b0, "R8 end", 64'(frm_valid), 64'd0);
      act = {fr[6], fr[5], fr[4], fr[3], fr[2], fr[1], fr[0]};
      chk(act === exp_frame, req, 64'(act), 64'(exp_frame));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk(frm_valid === 1'b0, "R1 idle", 64'(frm_valid), 64'd0);
      snap_now();
      drain("R1 zero frame");

      // R2 table walk
      foreach (VEC[n]) begin
         send(VEC[n][35:24], VEC[n][23:12], VEC[n][11:0]);
         snap_now();
         drain("R2 power sum");
      end

      // R5 codes without strobe
      smp_volt = 12'hFFF; smp_curr = 12'hFFF;
      repeat (5) @(negedge clk);
      snap_now();
      drain("R5 idle");

      // R3 first rollovers, then wrap of the rollover counter
      for (int i = 0; i < 20; i++) send(12'hFFF, 12'hFFF, 12'd4094);
      snap_now();
      drain("R3 carry");
      for (int i = 0; i < 4200; i++) send(12'hFFF, 12'hFFF, 12'd4094);
      snap_now();
      drain("R3 roll wrap R4 count");

      // R6 same-cycle sample is included
      smp_valid = 1'b1; smp_volt = 12'd3000; smp_curr = 12'd2000;
      model_add(12'd1464);
      snap_now();
      smp_valid = 1'b0;
      // R6 later samples leave frame alone; R8 byte held without ack
      smp_valid = 1'b1; smp_volt = 12'd2048; smp_curr = 12'd2048;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (2) @(negedge clk);
      chk(frm_byte === 8'd6 && frm_valid === 1'b1, "R8 hold", 64'(frm_byte), 64'd6);
      drain("R6 atomic");
      model_add(12'd1024);
      snap_now();
      drain("R6 no clear");

      // R9 restart mid-frame
      snap_now();
      frm_ack = 1'b1;
      repeat (2) @(negedge clk);
      frm_ack = 1'b0;
      send(12'd64, 12'd64, 12'd1);
      snap_now();
      chk(frm_byte === 8'd6, "R9 restart", 64'(frm_byte), 64'd6);
      drain("R9 fresh");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule